// File: doc/BRIEF.md
# NRU / RRIP Cache Replacement Selector

This block keeps the replacement state of every set of an N-way set-associative cache and names the way to evict. It is built in one of two variants chosen by a parameter. The not-recently-used variant keeps one bit per way. The re-reference variant keeps a 3-bit prediction per way. The block holds no tags and no data. The cache controller presents one set index per cycle, together with a hit notice, a fill notice and a victim request for that set.

A victim answer is combinational from the stored state of the addressed set. In the re-reference variant it can happen that no way of the set is ready for eviction. The block then ages the whole set by one step, keeps the valid flag low, and expects the request to be held. Each such cycle moves the set one step closer to having a candidate. Newly filled lines start one step short of eviction, so a line that is filled and never reused leaves the cache early.

Top module: `repl_select`

## Requirements
- R1: After reset every way of every set is an eviction candidate (NRU bit 1, RRIP value 7), so the first victim request to any set returns way 0 with the valid flag high.
- R2: In NRU mode a hit or a fill on a way clears that way's bit to 0.
- R3: In NRU mode, when an update would leave every bit of the set at 0, all bits of that set become 1, so an NRU victim request is always answered in the same cycle.
- R4: In NRU mode the victim is the lowest-numbered way whose bit is 1.
- R5: In RRIP mode a hit sets that way's value to 0.
- R6: In RRIP mode a fill sets that way's value to 6. When a hit and a fill name the same way in one cycle, the fill wins.
- R7: In RRIP mode the victim is the lowest-numbered way whose value is 7, reported in the same cycle as the request.
- R8: In RRIP mode a victim request that finds no value 7 raises every value of that set by one at the next clock edge and leaves the valid flag low. A held request repeats the search each cycle until a way reaches 7.
- R9: The valid flag is high only in a cycle where a victim is requested.
- R10: Updates in one cycle apply in a fixed order: ageing first, then the hit, then the fill. The victim search reads the state as it was before that cycle's updates. Only the addressed set changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; every set returns to all-candidate state |
| set_idx | input | $clog2(SETS) | Set addressed this cycle by all strobes |
| hit_valid | input | 1 | A hit occurred on `hit_way` |
| hit_way | input | $clog2(WAYS) | Way that was hit |
| fill_valid | input | 1 | A new line was placed in `fill_way` |
| fill_way | input | $clog2(WAYS) | Way that was filled |
| vict_req | input | 1 | Request for a victim in the addressed set |
| vict_valid | output | 1 | `vict_way` holds a victim this cycle |
| vict_way | output | $clog2(WAYS) | Chosen victim way |

## Verification
Ageing and an update can fall in the same cycle. A victim request that finds no value 7 can coincide with a hit or a fill to the same set, and the result then depends on the order: age, then hit, then fill. The bench provokes this with directed cycles that raise the request together with a hit, with a fill, and with both on one way. A long random phase confined to two sets then produces many more such collisions. A behavioural model that applies the three steps in that order is compared with both the NRU and the RRIP instance on every clock.

// File: rtl/repl_pkg.sv
package repl_pkg;

  typedef enum logic {
    REPL_NRU  = 1'b0,
    REPL_RRIP = 1'b1
  } repl_mode_e;

  // Bits of state held per way for a given variant.
  function automatic int way_bits(input repl_mode_e mode, input int rrpv_w);
    return (mode == REPL_RRIP) ? rrpv_w : 1;
  endfunction

endpackage

// File: rtl/repl_victim_find.sv
module repl_victim_find #(
  parameter int WAYS = 4,
  parameter int W    = 3,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][W-1:0] row,
  output logic                   found,
  output logic [WAY_W-1:0]       way
);

  logic [WAYS-1:0] cand;

  for (genvar g = 0; g < WAYS; g++) begin : g_cand
    assign cand[g] = (row[g] == {W{1'b1}});
  end

  // Lowest set bit wins.
  function automatic logic [WAY_W-1:0] lowest(input logic [WAYS-1:0] c);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (c[i]) r = WAY_W'(i);
    end
    return r;
  endfunction

  assign found = |cand;
  assign way   = lowest(cand);

endmodule

// File: rtl/repl_set_next.sv
module repl_set_next
  import repl_pkg::*;
#(
  parameter int         WAYS = 4,
  parameter int         W    = 3,
  parameter repl_mode_e MODE = REPL_RRIP,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][W-1:0] cur,
  input  logic                   age,
  input  logic                   hit_v,
  input  logic [WAY_W-1:0]       hit_way,
  input  logic                   fill_v,
  input  logic [WAY_W-1:0]       fill_way,
  output logic [WAYS-1:0][W-1:0] nxt
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] INSV = MAXV - W'(1);  // 6 for RRIP, 0 for NRU

  function automatic logic [WAYS-1:0][W-1:0] age_row(input logic [WAYS-1:0][W-1:0] r);
    logic [WAYS-1:0][W-1:0] o;
    for (int i = 0; i < WAYS; i++) o[i] = r[i] + W'(1);
    return o;
  endfunction

  logic [WAYS-1:0][W-1:0] upd;

  // Order: age, then hit, then fill.
  always_comb begin
    upd = cur;
    if (age)    upd = age_row(upd);
    if (hit_v)  upd[hit_way]  = '0;
    if (fill_v) upd[fill_way] = INSV;
  end

  if (MODE == REPL_NRU) begin : g_nru
    logic all_clear;
    assign all_clear = (upd == '0);
    assign nxt = all_clear ? '1 : upd;
  end else begin : g_rrip
    assign nxt = upd;
  end

endmodule

// File: rtl/repl_state_bank.sv
module repl_state_bank #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int W    = 3,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SET_W-1:0]       idx,
  output logic [WAYS-1:0][W-1:0] rd_row,
  input  logic                   wr_en,
  input  logic [WAYS-1:0][W-1:0] wr_row
);

  logic [WAYS-1:0][W-1:0] rows [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          rows[s] <= '1;
      else if (wr_en && idx == SET_W'(s))  rows[s] <= wr_row;
    end
  end

  assign rd_row = rows[idx];

endmodule

// File: rtl/repl_select.sv
module repl_select
  import repl_pkg::*;
#(
  parameter int         WAYS   = 4,
  parameter int         SETS   = 16,
  parameter int         RRPV_W = 3,
  parameter repl_mode_e MODE   = REPL_RRIP,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int W     = way_bits(MODE, RRPV_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_idx,
  input  logic             hit_valid,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_valid,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             vict_req,
  output logic             vict_valid,
  output logic [WAY_W-1:0] vict_way
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [WAYS-1:0][W-1:0] cur;
  logic [WAYS-1:0][W-1:0] nxt;
  logic                   found;
  logic                   age_evt;
  logic                   wr_evt;

  repl_state_bank #(.SETS(SETS), .WAYS(WAYS), .W(W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx    (set_idx),
    .rd_row (cur),
    .wr_en  (wr_evt),
    .wr_row (nxt)
  );

  repl_victim_find #(.WAYS(WAYS), .W(W)) u_find (
    .row   (cur),
    .found (found),
    .way   (vict_way)
  );

  assign age_evt    = vict_req && !found;
  assign wr_evt     = age_evt || hit_valid || fill_valid;
  assign vict_valid = vict_req && found;

  repl_set_next #(.WAYS(WAYS), .W(W), .MODE(MODE)) u_next (
    .cur      (cur),
    .age      (age_evt),
    .hit_v    (hit_valid),
    .hit_way  (hit_way),
    .fill_v   (fill_valid),
    .fill_way (fill_way),
    .nxt      (nxt)
  );

  // ---------------- assertions ----------------
  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  function automatic logic [WAYS-1:0][W-1:0] step_up(input logic [WAYS-1:0][W-1:0] r);
    logic [WAYS-1:0][W-1:0] o;
    for (int i = 0; i < WAYS; i++) o[i] = r[i] + W'(1);
    return o;
  endfunction

  a_r9_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    vict_valid |-> vict_req);

  a_r7_victim_is_max: assert property (@(posedge clk) disable iff (!rst_n)
    vict_valid |-> cur[vict_way] == MAXV);

  if (MODE == REPL_NRU) begin : g_chk_nru
    a_r3_nru_always_found: assert property (@(posedge clk) disable iff (!rst_n)
      vict_req |-> vict_valid);
  end else begin : g_chk_rrip
    a_r5_hit_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(hit_valid) && set_idx == $past(set_idx) &&
       !($past(fill_valid) && $past(fill_way) == $past(hit_way)))
      |-> cur[$past(hit_way)] == '0);

    a_r6_fill_six: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(fill_valid) && set_idx == $past(set_idx))
      |-> cur[$past(fill_way)] == MAXV - W'(1));

    a_r8_age_step: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(age_evt) && !$past(hit_valid) && !$past(fill_valid) &&
       set_idx == $past(set_idx))
      |-> cur == step_up($past(cur)));
  end

endmodule

// File: tb/repl_select_tb.sv
`timescale 1ns/1ps
module repl_select_tb;
  import repl_pkg::*;

  localparam int WAYS = 4;
  localparam int SETS = 8;
  localparam int WAY_W = $clog2(WAYS);
  localparam int SET_W = $clog2(SETS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SET_W-1:0] set_idx = '0;
  logic hit_valid = 1'b0, fill_valid = 1'b0, vict_req = 1'b0;
  logic [WAY_W-1:0] hit_way = '0, fill_way = '0;
  logic vv_r, vv_n;
  logic [WAY_W-1:0] vw_r, vw_n;

  always #2 clk = ~clk;

  repl_select #(.WAYS(WAYS), .SETS(SETS), .RRPV_W(3), .MODE(REPL_RRIP)) u_dut (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_valid(hit_valid),
    .hit_way(hit_way), .fill_valid(fill_valid), .fill_way(fill_way),
    .vict_req(vict_req), .vict_valid(vv_r), .vict_way(vw_r));

  repl_select #(.WAYS(WAYS), .SETS(SETS), .RRPV_W(3), .MODE(REPL_NRU)) u_dut_nru (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_valid(hit_valid),
    .hit_way(hit_way), .fill_valid(fill_valid), .fill_way(fill_way),
    .vict_req(vict_req), .vict_valid(vv_n), .vict_way(vw_n));

  // model: index 0 = NRU (max 1), 1 = RRIP (max 7)
  int m [2][SETS][WAYS];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic int maxv(input int md);
    return (md == 1) ? 7 : 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic search(input int md, input int s, output bit f, output int w);
    f = 0; w = 0;
    for (int i = WAYS - 1; i >= 0; i--) if (m[md][s][i] == maxv(md)) begin f = 1; w = i; end
  endtask

  task automatic apply(input int md, input int s, input bit age, input bit hv, input int hw,
                       input bit fv, input int fw);
    int zeros;
    if (age) for (int i = 0; i < WAYS; i++) m[md][s][i]++;
    if (hv) m[md][s][hw] = 0;
    if (fv) m[md][s][fw] = maxv(md) - 1;
    if (md == 0) begin
      zeros = 0;
      for (int i = 0; i < WAYS; i++) if (m[md][s][i] == 0) zeros++;
      if (zeros == WAYS) for (int i = 0; i < WAYS; i++) m[md][s][i] = 1;
    end
  endtask

  // One cycle: drive at negedge, compare, clock, update model.
  task automatic step(input int s, input bit hv, input int hw, input bit fv, input int fw,
                      input bit vr, input string tag_n, input string tag_r);
    bit f0, f1; int w0, w1;
    set_idx = SET_W'(s); hit_valid = hv; hit_way = WAY_W'(hw);
    fill_valid = fv; fill_way = WAY_W'(fw); vict_req = vr;
    #1;
    search(0, s, f0, w0);
    search(1, s, f1, w1);
    chk(vv_n == (vr && f0), {tag_n, " nru valid"}, int'(vv_n), int'(vr && f0));
    if (vr && f0) chk(int'(vw_n) == w0, {tag_n, " nru way"}, int'(vw_n), w0);
    chk(vv_r == (vr && f1), {tag_r, " rrip valid"}, int'(vv_r), int'(vr && f1));
    if (vr && f1) chk(int'(vw_r) == w1, {tag_r, " rrip way"}, int'(vw_r), w1);
    @(posedge clk);
    apply(0, s, vr && !f0, hv, hw, fv, fw);
    apply(1, s, vr && !f1, hv, hw, fv, fw);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int md = 0; md < 2; md++)
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) m[md][s][w] = maxv(md);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R9: idle outputs, then first victim of every set is way 0
    step(0, 0, 0, 0, 0, 0, "R9", "R9");
    for (int s = 0; s < SETS; s++) step(s, 0, 0, 0, 0, 1, "R1", "R1");

    // R2 / R6 / R3: fill every way of set 2
    for (int w = 0; w < WAYS; w++) step(2, 0, 0, 1, w, 0, "R2", "R6");
    // R3 NRU answered at once; R8 RRIP ages 6->7 then answers way 0 (R7)
    step(2, 0, 0, 0, 0, 1, "R3", "R8");
    step(2, 0, 0, 0, 0, 1, "R4", "R7");
    // R5 / R2: hit way 0 then victim should be way 1
    step(2, 1, 0, 0, 0, 0, "R2", "R5");
    step(2, 0, 0, 0, 0, 1, "R4", "R7");
    // R10: hit and request together; search sees pre-hit state
    step(2, 1, 1, 0, 0, 1, "R10", "R10");
    step(2, 0, 0, 0, 0, 1, "R4", "R7");
    // R6 / R10: hit and fill on one way, fill wins
    step(2, 1, 3, 1, 3, 0, "R10", "R6");
    step(2, 0, 0, 0, 0, 1, "R4", "R7");
    // R8: clear every way, then hold the request through full ageing
    for (int w = 0; w < WAYS; w++) step(5, 1, w, 0, 0, 0, "R3", "R5");
    for (int c = 0; c < 9; c++) step(5, 0, 0, 0, 0, 1, "R3", "R8");
    // R10: ageing together with a fill in the same set
    for (int w = 0; w < WAYS; w++) step(6, 1, w, 0, 0, 0, "R2", "R5");
    step(6, 0, 0, 1, 2, 1, "R10", "R10");
    for (int c = 0; c < 8; c++) step(6, 0, 0, 0, 0, 1, "R10", "R8");
    // R10: other sets untouched
    step(7, 0, 0, 0, 0, 1, "R10", "R10");

    // random collisions confined to two sets
    for (int i = 0; i < 4000; i++)
      step(int'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), int'($urandom_range(0, WAYS - 1)),
           bit'($urandom_range(0, 2) == 0), int'($urandom_range(0, WAYS - 1)),
           bit'($urandom_range(0, 1)), "R4", "R8");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule